// File: doc/BRIEF.md
# Display Window Update Sequencer

This block updates one rectangular region in the frame memory of a display controller that uses the common command set. A requester gives the first and last column and the first and last row of the region. All four bounds are inclusive. The block adds fixed panel offsets to these coordinates. It then emits three commands, each with its parameters: the column range, the row range, and the memory write. After that it passes pixel bytes through to the output. Every byte leaves on one byte stream that uses a valid/ready handshake. A flag on that stream marks each byte as a command or as data.

Pixel bytes arrive on a valid/ready input stream and reach the output unchanged. Each pixel takes two bytes. The block stops after exactly (columns × rows × 2) bytes. A blanking request ignores the coordinates it is given and covers the whole panel. In that case the block generates the zero bytes itself and does not read the pixel input. While an update is running the block reports busy and ignores any new request.

Top module: `win_update_seq`

## Requirements
- R1: After reset, busy, out_valid and pix_ready are all low.
- R2: When the block is idle, a request with req_valid high is accepted on that clock edge. From the next cycle, busy is high and the output offers byte 0x2A with out_dc low.
- R3: The four bytes after 0x2A are data bytes in this order: high byte then low byte of (first column + COL_OFS), then high byte then low byte of (last column + COL_OFS). Each coordinate is carried as a 16-bit value.
- R4: Command byte 0x2B follows. It is followed by (first row + ROW_OFS) and (last row + ROW_OFS), using the same high-then-low byte order.
- R5: Command byte 0x2C follows. After it come exactly (last column − first column + 1) × (last row − first row + 1) × 2 data bytes, and then nothing more.
- R6: out_dc is low for the three command bytes 0x2A, 0x2B and 0x2C. It is high for every parameter byte and every pixel byte.
- R7: A request with req_blank high ignores the request coordinates. It uses columns 0 to PANEL_W−1 and rows 0 to PANEL_H−1, with the offsets added. Every pixel byte it emits is 0x00, and pix_ready stays low for the whole update.
- R8: busy stays high from the cycle after acceptance until the last pixel byte is accepted, and drops in the next cycle. A request made while busy is high has no effect.
- R9: During pixel streaming, a byte goes out only when the pixel input offers one. When the pixel input stalls, no filler byte is emitted. The pixel bytes leave in the order they arrived, with their values unchanged.
- R10: A command or parameter byte that is offered but not accepted keeps the same value and flag until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Update request strobe |
| req_blank | input | 1 | Request is a full-panel blanking update |
| req_col_first | input | COORD_W | First column, inclusive |
| req_col_last | input | COORD_W | Last column, inclusive |
| req_row_first | input | COORD_W | First row, inclusive |
| req_row_last | input | COORD_W | Last row, inclusive |
| busy | output | 1 | An update is in progress |
| pix_valid | input | 1 | Pixel byte available |
| pix_data | input | 8 | Pixel byte |
| pix_ready | output | 1 | Pixel byte taken |
| out_valid | output | 1 | Output byte available |
| out_data | output | 8 | Output byte |
| out_dc | output | 1 | 0 = command byte, 1 = data byte |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The hardest situations to reach from the ports are two: a stall on the pixel input and backpressure on the output in the same cycles, and a request that arrives in the middle of an update. The stimulus stalls the pixel source every third cycle and the output every fourth cycle. This way every combination of the two stalls occurs during both the header and the pixel phase. Each pixel byte carries a value derived from its position in the stream, so any dropped, repeated or filler byte shows up as a mismatch. For the ignore case, a second request with different coordinates is held for several cycles during an update. The bench then checks that the byte count and the header match only the first request.

// File: rtl/win_pkg.sv
package win_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_PIX  = 2'd2
    } phase_e;

    localparam logic [7:0] CMD_COL_RANGE = 8'h2A;
    localparam logic [7:0] CMD_ROW_RANGE = 8'h2B;
    localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
    localparam int         HDR_BYTES     = 11;
endpackage

// File: rtl/win_coord_calc.sv
module win_coord_calc #(
    parameter int COORD_W = 16,
    parameter int COL_OFS = 0,
    parameter int ROW_OFS = 0,
    parameter int PANEL_W = 240,
    parameter int PANEL_H = 320,
    parameter int CNT_W   = 2 * COORD_W + 2
) (
    input  logic               blank,
    input  logic [COORD_W-1:0] col_first,
    input  logic [COORD_W-1:0] col_last,
    input  logic [COORD_W-1:0] row_first,
    input  logic [COORD_W-1:0] row_last,
    output logic [COORD_W-1:0] xs,
    output logic [COORD_W-1:0] xe,
    output logic [COORD_W-1:0] ys,
    output logic [COORD_W-1:0] ye,
    output logic [CNT_W-1:0]   nbytes
);
    logic [COORD_W-1:0] cf, cl, rf, rl;
    logic [COORD_W:0]   ncols, nrows;

    always_comb begin
        if (blank) begin
            cf = '0;
            cl = COORD_W'(PANEL_W - 1);
            rf = '0;
            rl = COORD_W'(PANEL_H - 1);
        end else begin
            cf = col_first;
            cl = col_last;
            rf = row_first;
            rl = row_last;
        end
        xs = cf + COORD_W'(COL_OFS);
        xe = cl + COORD_W'(COL_OFS);
        ys = rf + COORD_W'(ROW_OFS);
        ye = rl + COORD_W'(ROW_OFS);
        ncols  = {1'b0, cl} - {1'b0, cf} + 1'b1;
        nrows  = {1'b0, rl} - {1'b0, rf} + 1'b1;
        nbytes = (CNT_W'(ncols) * CNT_W'(nrows)) << 1;
    end
endmodule

// File: rtl/win_hdr_sel.sv
module win_hdr_sel
    import win_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic [3:0]         idx,
    input  logic [COORD_W-1:0] xs,
    input  logic [COORD_W-1:0] xe,
    input  logic [COORD_W-1:0] ys,
    input  logic [COORD_W-1:0] ye,
    output logic [7:0]         hdr_byte,
    output logic               hdr_is_cmd
);
    logic [15:0] xs16, xe16, ys16, ye16;

    always_comb begin
        xs16 = 16'(xs);
        xe16 = 16'(xe);
        ys16 = 16'(ys);
        ye16 = 16'(ye);
        hdr_is_cmd = 1'b0;
        case (idx)
            4'd0:    begin hdr_byte = CMD_COL_RANGE; hdr_is_cmd = 1'b1; end
            4'd1:    hdr_byte = xs16[15:8];
            4'd2:    hdr_byte = xs16[7:0];
            4'd3:    hdr_byte = xe16[15:8];
            4'd4:    hdr_byte = xe16[7:0];
            4'd5:    begin hdr_byte = CMD_ROW_RANGE; hdr_is_cmd = 1'b1; end
            4'd6:    hdr_byte = ys16[15:8];
            4'd7:    hdr_byte = ys16[7:0];
            4'd8:    hdr_byte = ye16[15:8];
            4'd9:    hdr_byte = ye16[7:0];
            default: begin hdr_byte = CMD_MEM_WRITE; hdr_is_cmd = 1'b1; end
        endcase
    end
endmodule

// File: rtl/win_update_seq.sv
module win_update_seq
    import win_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int COL_OFS = 0,
    parameter int ROW_OFS = 0,
    parameter int PANEL_W = 240,
    parameter int PANEL_H = 320
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_blank,
    input  logic [COORD_W-1:0] req_col_first,
    input  logic [COORD_W-1:0] req_col_last,
    input  logic [COORD_W-1:0] req_row_first,
    input  logic [COORD_W-1:0] req_row_last,
    output logic               busy,
    input  logic               pix_valid,
    input  logic [7:0]         pix_data,
    output logic               pix_ready,
    output logic               out_valid,
    output logic [7:0]         out_data,
    output logic               out_dc,
    input  logic               out_ready
);
    localparam int         CNT_W    = 2 * COORD_W + 2;
    localparam logic [3:0] HDR_LAST = 4'(HDR_BYTES - 1);

    typedef struct packed {
        phase_e             phase;
        logic [3:0]         idx;
        logic [CNT_W-1:0]   remain;
        logic               blank;
        logic [COORD_W-1:0] xs;
        logic [COORD_W-1:0] xe;
        logic [COORD_W-1:0] ys;
        logic [COORD_W-1:0] ye;
    } seq_t;

    seq_t st_d, st_q;

    logic [COORD_W-1:0] c_xs, c_xe, c_ys, c_ye;
    logic [CNT_W-1:0]   c_nbytes;
    logic [7:0]         hdr_byte;
    logic               hdr_is_cmd;
    logic               fire;

    win_coord_calc #(
        .COORD_W(COORD_W), .COL_OFS(COL_OFS), .ROW_OFS(ROW_OFS),
        .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .CNT_W(CNT_W)
    ) u_calc (
        .blank    (req_blank),
        .col_first(req_col_first),
        .col_last (req_col_last),
        .row_first(req_row_first),
        .row_last (req_row_last),
        .xs       (c_xs),
        .xe       (c_xe),
        .ys       (c_ys),
        .ye       (c_ye),
        .nbytes   (c_nbytes)
    );

    win_hdr_sel #(.COORD_W(COORD_W)) u_hdr (
        .idx       (st_q.idx),
        .xs        (st_q.xs),
        .xe        (st_q.xe),
        .ys        (st_q.ys),
        .ye        (st_q.ye),
        .hdr_byte  (hdr_byte),
        .hdr_is_cmd(hdr_is_cmd)
    );

    always_comb begin
        st_d      = st_q;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_dc    = 1'b0;
        pix_ready = 1'b0;
        fire      = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase  = PH_HDR;
                    st_d.idx    = '0;
                    st_d.remain = c_nbytes;
                    st_d.blank  = req_blank;
                    st_d.xs     = c_xs;
                    st_d.xe     = c_xe;
                    st_d.ys     = c_ys;
                    st_d.ye     = c_ye;
                end
            end
            PH_HDR: begin
                out_valid = 1'b1;
                out_data  = hdr_byte;
                out_dc    = ~hdr_is_cmd;
                if (out_ready) begin
                    if (st_q.idx == HDR_LAST) begin
                        st_d.phase = PH_PIX;
                    end else begin
                        st_d.idx = st_q.idx + 4'd1;
                    end
                end
            end
            PH_PIX: begin
                out_dc = 1'b1;
                if (st_q.blank) begin
                    out_valid = 1'b1;
                    out_data  = 8'h00;
                end else begin
                    out_valid = pix_valid;
                    out_data  = pix_data;
                    pix_ready = out_ready;
                end
                fire = out_valid && out_ready;
                if (fire) begin
                    st_d.remain = st_q.remain - 1'b1;
                    if (st_q.remain == CNT_W'(1)) begin
                        st_d.phase = PH_IDLE;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase != PH_IDLE);

    // R2: acceptance from idle starts the column-range command next cycle
    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> (busy && out_valid && out_data == CMD_COL_RANGE && !out_dc));

    // R6: a byte flagged as command is always one of the three commands
    p_cmd_codes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_dc) |->
        (out_data == CMD_COL_RANGE || out_data == CMD_ROW_RANGE || out_data == CMD_MEM_WRITE));

    // R7: blanking emits zero bytes and never pulls pixels
    p_blank_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_PIX && st_q.blank) |-> (out_valid && out_data == 8'h00 && !pix_ready));

    // R8: pixels are only drawn during an update
    p_pix_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> busy);

    // R8: a request while busy leaves the header position untouched
    p_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && st_q.phase == PH_HDR && !out_ready) |=> $stable(st_q.idx));

    // R9: an accepted pixel byte passes unchanged as data
    p_pix_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pix_ready) |-> (out_valid && out_ready && out_dc && out_data == pix_data));

    // R10: a stalled header byte holds its value and flag
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_HDR && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dc)));
endmodule

// File: tb/tb_win_update_seq.sv
`timescale 1ns/1ps
module tb_win_update_seq;
    localparam int CW   = 16;
    localparam int COFS = 300;
    localparam int ROFS = 5;
    localparam int PW   = 8;
    localparam int PH   = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_blank = 1'b0;
    logic [CW-1:0] req_col_first = '0, req_col_last = '0;
    logic [CW-1:0] req_row_first = '0, req_row_last = '0;
    logic          busy;
    logic          pix_valid = 1'b0;
    logic [7:0]    pix_data = 8'h00;
    logic          pix_ready;
    logic          out_valid;
    logic [7:0]    out_data;
    logic          out_dc;
    logic          out_ready = 1'b1;

    always #4 clk = ~clk;

    win_update_seq #(
        .COORD_W(CW), .COL_OFS(COFS), .ROW_OFS(ROFS), .PANEL_W(PW), .PANEL_H(PH)
    ) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_blank(req_blank),
        .req_col_first(req_col_first), .req_col_last(req_col_last),
        .req_row_first(req_row_first), .req_row_last(req_row_last),
        .busy(busy),
        .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
        .out_valid(out_valid), .out_data(out_data), .out_dc(out_dc),
        .out_ready(out_ready)
    );

    int total = 0;
    int bad   = 0;

    // stimulus knobs
    logic src_en = 1'b0, pstall = 1'b0, ostall = 1'b0;
    logic cap_clr = 1'b0, blank_mode = 1'b0;

    // capture state
    logic [7:0] cap_data [0:511];
    logic       cap_dc   [0:511];
    int         n = 0, filler = 0, hold_err = 0;
    logic       pr_seen = 1'b0, hold_pend = 1'b0, fire_s = 1'b0;
    logic [7:0] hold_d = 8'h00;
    logic       hold_dc = 1'b0;
    int         pk = 0, cyc = 0;

    // pixel source and output backpressure, driven 1 ns after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (!src_en) pk = 0;
        else if (fire_s) pk = pk + 1;
        cyc = cyc + 1;
        pix_data  = 8'(pk * 7 + 3);
        pix_valid = src_en && !(pstall && (cyc % 3 == 0));
        out_ready = !(ostall && (cyc % 4 == 1));
    end

    // monitor at the falling edge
    always @(negedge clk) begin
        fire_s = pix_valid && pix_ready;
        if (cap_clr) begin
            n = 0; filler = 0; hold_err = 0; pr_seen = 1'b0; hold_pend = 1'b0;
        end else if (rst_n) begin
            if (pix_ready) pr_seen = 1'b1;
            if (hold_pend && (out_data != hold_d || out_dc != hold_dc || !out_valid))
                hold_err = hold_err + 1;
            hold_pend = out_valid && !out_ready && busy && (n < 11);
            hold_d    = out_data;
            hold_dc   = out_dc;
            if (out_valid && out_ready) begin
                if (n < 512) begin
                    cap_data[n] = out_data;
                    cap_dc[n]   = out_dc;
                end
                if (n >= 11 && !blank_mode && !pix_valid) filler = filler + 1;
                n = n + 1;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        total = total + 1;
        bad   = bad + 1;
        $display("FAIL watchdog act=expired exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    function automatic logic [7:0] hdr_exp(input int i, input int xs, input int xe,
                                           input int ys, input int ye);
        case (i)
            0: return 8'h2A;
            1: return 8'(xs >> 8);
            2: return 8'(xs);
            3: return 8'(xe >> 8);
            4: return 8'(xe);
            5: return 8'h2B;
            6: return 8'(ys >> 8);
            7: return 8'(ys);
            8: return 8'(ye >> 8);
            9: return 8'(ye);
            default: return 8'h2C;
        endcase
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy && !out_valid && !pix_ready, "R1 reset outputs idle",
            {busy, out_valid, pix_ready}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
    endtask

    task automatic t_window(input string name, input int cf, input int cl, input int rf,
                            input int rl, input logic blk, input logic ps, input logic os,
                            input logic poke);
        int xs, xe, ys, ye, nb, wait_cnt;
        logic hdr_ok, dc_ok, dat_ok;
        if (blk) begin
            xs = COFS; xe = PW - 1 + COFS; ys = ROFS; ye = PH - 1 + ROFS;
            nb = PW * PH * 2;
        end else begin
            xs = cf + COFS; xe = cl + COFS; ys = rf + ROFS; ye = rl + ROFS;
            nb = (cl - cf + 1) * (rl - rf + 1) * 2;
        end
        @(posedge clk); #1;
        src_en = 1'b0; pstall = ps; ostall = os; blank_mode = blk;
        cap_clr = 1'b1;
        @(negedge clk);
        @(posedge clk); #2;
        cap_clr = 1'b0;
        src_en  = 1'b1;
        req_valid = 1'b1; req_blank = blk;
        req_col_first = CW'(cf); req_col_last = CW'(cl);
        req_row_first = CW'(rf); req_row_last = CW'(rl);
        @(posedge clk); #2;
        req_valid = 1'b0;
        req_col_first = '1; req_col_last = '1; req_row_first = '1; req_row_last = '1;
        @(negedge clk);
        chk(busy && out_valid && out_data == 8'h2A && !out_dc,
            {"R2 first byte after accept ", name}, {busy, out_valid, out_dc, out_data}, 'h62A);
        if (poke) begin
            @(posedge clk); #2;
            req_valid = 1'b1; req_blank = 1'b0;
            req_col_first = 16'd1; req_col_last = 16'd40;
            req_row_first = 16'd2; req_row_last = 16'd30;
            repeat (3) @(posedge clk);
            #2;
            req_valid = 1'b0;
        end
        wait_cnt = 0;
        while (busy && wait_cnt < 4000) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(!busy, {"R8 busy drops after last byte ", name}, busy, 0);
        chk(n == 11 + nb, {"R5 byte count ", name}, n, 11 + nb);
        hdr_ok = 1'b1;
        for (int i = 0; i < 5; i++)
            if (cap_data[i] != hdr_exp(i, xs, xe, ys, ye)) hdr_ok = 1'b0;
        chk(hdr_ok, {"R3 column command and parameters ", name}, cap_data[2], 8'(xs));
        hdr_ok = 1'b1;
        for (int i = 5; i < 10; i++)
            if (cap_data[i] != hdr_exp(i, xs, xe, ys, ye)) hdr_ok = 1'b0;
        chk(hdr_ok, {"R4 row command and parameters ", name}, cap_data[7], 8'(ys));
        chk(cap_data[10] == 8'h2C, {"R5 memory write command ", name}, cap_data[10], 'h2C);
        dc_ok = 1'b1;
        for (int i = 0; i < 11 + nb && i < 512; i++)
            if (cap_dc[i] != !(i == 0 || i == 5 || i == 10)) dc_ok = 1'b0;
        chk(dc_ok, {"R6 command/data flags ", name}, dc_ok, 1);
        dat_ok = 1'b1;
        for (int j = 0; j < nb && 11 + j < 512; j++)
            if (cap_data[11 + j] != (blk ? 8'h00 : 8'(j * 7 + 3))) dat_ok = 1'b0;
        if (blk) begin
            chk(dat_ok, {"R7 blank bytes are zero ", name}, dat_ok, 1);
            chk(!pr_seen, {"R7 pixel input untouched ", name}, pr_seen, 0);
        end else begin
            chk(dat_ok, {"R9 pixel bytes in order ", name}, dat_ok, 1);
            chk(filler == 0, {"R9 no filler bytes ", name}, filler, 0);
        end
        chk(hold_err == 0, {"R10 stalled header held ", name}, hold_err, 0);
        repeat (3) @(negedge clk);
        chk(!busy && !out_valid, {"R8 stays idle after update ", name}, {busy, out_valid}, 0);
        @(posedge clk); #1;
        src_en = 1'b0; pstall = 1'b0; ostall = 1'b0; blank_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_window("small", 0, 3, 0, 1, 1'b0, 1'b0, 1'b0, 1'b0);
        t_window("stalled", 250, 260, 10, 12, 1'b0, 1'b1, 1'b1, 1'b0);
        t_window("single pixel", 7, 7, 9, 9, 1'b0, 1'b1, 1'b0, 1'b0);
        t_window("blank", 900, 901, 700, 702, 1'b1, 1'b0, 1'b1, 1'b0);
        t_window("ignore while busy", 2, 4, 3, 3, 1'b0, 1'b0, 1'b1, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule